// File: doc/BRIEF.md
# Masked Repeating Alarm Comparator

This block holds four alarm registers (seconds, minutes, hours and day-of-month) in BCD and compares them against the current BCD time fields supplied by an external calendar counter. On each one-second tick it checks for a match. A match produces a single-cycle interrupt pulse, provided the interrupt-enable bit is set.

Bit 7 of every alarm register is a "don't care" flag. The combination of the four flags sets how often the alarm repeats: monthly, daily, hourly, per minute or per second. When software writes a value that is not a legal BCD number for its field, the write is dropped and the register keeps its previous contents. A register write port and a combinational read port give access to the alarm registers and the control register. The calendar counter itself is outside this block.

Top module: `rpt_alarm_cmp`

## Requirements
- R1: Register map on `wr_addr`/`rd_addr`:
  - 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm day-of-month.
  - 4 = control, where bit 0 is the interrupt enable and the other bits read 0.
  - Every other address reads 0x00, and writes to it change nothing.
  - A write to one address leaves all other registers unchanged.
- R2: While `rst_n` is low, all four alarm registers and the enable bit are cleared and `irq_pulse` is 0. They read back as 0x00 after reset.
- R3: An alarm-seconds or alarm-minutes write is stored (all 8 bits) only when bits [6:4] are 0 to 5 and bits [3:0] are 0 to 9. Otherwise the register keeps its old value.
- R4: An alarm-hours write is stored (all 8 bits) only when bits [3:0] are 0 to 9 and the BCD value of bits [5:0] is 0 to 23. Otherwise it is dropped.
- R5: An alarm-date write is stored (all 8 bits) only when bits [3:0] are 0 to 9 and the BCD value of bits [4:0] is not zero. Otherwise it is dropped.
- R6: With all four bit-7 flags clear, a tick fires when all four fields match. Matching compares bits [6:0] for seconds and minutes, [5:0] for hours and [4:0] for date. This gives a monthly repeat.
- R7: With only the date flag set, a tick fires when hours, minutes and seconds match (daily).
- R8: With only the date and hour flags set, a tick fires when minutes and seconds match (hourly).
- R9: With only the date, hour and minute flags set, a tick fires when seconds match (per minute).
- R10: Any other flag combination fires on every tick.
- R11: `irq_pulse` is high only in the cycle after a cycle in which `tick` was high and the fire condition held. Without a tick it stays low even when the fields match.
- R12: When the enable bit is 0, `irq_pulse` stays low whatever the match state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational register readback |
| tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day-of-month, BCD |
| irq_pulse | output | 1 | Single-cycle alarm interrupt |

## Verification
The following are checked on every cycle:
- Every interrupt pulse follows a tick cycle in which the enable bit was set.
- The stored seconds and hours registers never hold an out-of-range BCD value.
- Writes aimed at other addresses never disturb the seconds register.

Other behaviours need the bench's scenarios:
- Selecting the repeat rate from each flag combination.
- The field-by-field compare for those rates.
- Rejection of each class of illegal write.

// File: rtl/rpt_alarm_pkg.sv
package rpt_alarm_pkg;
   localparam int NUM_FIELDS = 4;
   localparam int REG_W      = 8;
   // per field: seconds, minutes, hours, date
   localparam int FLD_W   [NUM_FIELDS] = '{7, 7, 6, 5};
   localparam int FLD_MIN [NUM_FIELDS] = '{0, 0, 0, 1};
   localparam int FLD_MAX [NUM_FIELDS] = '{59, 59, 23, 99};

   // true when the low 'bits' of v form a BCD value within [lo, hi]
   function automatic logic bcd_in_range(input logic [REG_W-1:0] v,
                                         input int bits, input int lo, input int hi);
      logic [REG_W-1:0] m;
      int units;
      int tens;
      int val;
      m     = v & REG_W'((1 << bits) - 1);
      units = int'(m[3:0]);
      tens  = int'(m[7:4]);
      val   = tens * 10 + units;
      return (units <= 9) && (val >= lo) && (val <= hi);
   endfunction
endpackage

// File: rtl/rpt_alarm_field.sv
module rpt_alarm_field
   import rpt_alarm_pkg::*;
#(
   parameter int VAL_W   = 7,
   parameter int MIN_VAL = 0,
   parameter int MAX_VAL = 59
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic [REG_W-1:0] now_val,
   output logic [REG_W-1:0] reg_q,
   output logic             mask,
   output logic             hit
);
   localparam logic [REG_W-1:0] VMASK = REG_W'((1 << VAL_W) - 1);

   if (VAL_W < 4 || VAL_W > REG_W - 1) begin : g_bad_w
      $error("rpt_alarm_field: VAL_W out of range");
   end
   if (MIN_VAL > MAX_VAL) begin : g_bad_rng
      $error("rpt_alarm_field: MIN_VAL above MAX_VAL");
   end

   logic legal;
   assign legal = bcd_in_range(wr_data, VAL_W, MIN_VAL, MAX_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         reg_q <= '0;
      else if (wr_sel && legal)
         reg_q <= wr_data;
   end

   assign mask = reg_q[REG_W-1];
   assign hit  = ((now_val ^ reg_q) & VMASK) == '0;
endmodule

// File: rtl/rpt_alarm_rate.sv
module rpt_alarm_rate
   import rpt_alarm_pkg::*;
(
   input  logic [NUM_FIELDS-1:0] mask,   // [0]=sec [1]=min [2]=hour [3]=date
   input  logic [NUM_FIELDS-1:0] hit,
   output logic                  fire_ok
);
   if (NUM_FIELDS != 4) begin : g_bad_n
      $error("rpt_alarm_rate: decode assumes four fields");
   end

   logic [NUM_FIELDS-1:0] need;

   always_comb begin
      unique case (mask)
         4'b0000: need = 4'b1111;   // monthly
         4'b1000: need = 4'b0111;   // daily
         4'b1100: need = 4'b0011;   // hourly
         4'b1110: need = 4'b0001;   // per minute
         default: need = 4'b0000;   // per second
      endcase
   end

   assign fire_ok = &(hit | ~need);
endmodule

// File: rtl/rpt_alarm_cmp.sv
module rpt_alarm_cmp
   import rpt_alarm_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int CTRL_ADDR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              tick,
   input  logic [REG_W-1:0]  now_sec,
   input  logic [REG_W-1:0]  now_min,
   input  logic [REG_W-1:0]  now_hour,
   input  logic [REG_W-1:0]  now_date,
   output logic              irq_pulse
);
   if (CTRL_ADDR < NUM_FIELDS || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_ctrl
      $error("rpt_alarm_cmp: CTRL_ADDR collides or is unreachable");
   end

   logic [NUM_FIELDS-1:0][REG_W-1:0] now_vec;
   logic [NUM_FIELDS-1:0][REG_W-1:0] fld_q;
   logic [NUM_FIELDS-1:0]            fld_mask;
   logic [NUM_FIELDS-1:0]            fld_hit;
   logic                             fire_ok;
   logic                             en_q;

   assign now_vec = {now_date, now_hour, now_min, now_sec};

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      rpt_alarm_field #(
         .VAL_W   (FLD_W[g]),
         .MIN_VAL (FLD_MIN[g]),
         .MAX_VAL (FLD_MAX[g])
      ) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (wr_en && (wr_addr == ADDR_W'(g))),
         .wr_data (wr_data),
         .now_val (now_vec[g]),
         .reg_q   (fld_q[g]),
         .mask    (fld_mask[g]),
         .hit     (fld_hit[g])
      );
   end

   rpt_alarm_rate u_rate (
      .mask    (fld_mask),
      .hit     (fld_hit),
      .fire_ok (fire_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
         en_q <= wr_data[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_pulse <= 1'b0;
      else
         irq_pulse <= tick && fire_ok && en_q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_FIELDS; k++)
         if (rd_addr == ADDR_W'(k)) rd_data = fld_q[k];
      if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = {{(REG_W-1){1'b0}}, en_q};
   end
endmodule

// File: rtl/rpt_alarm_chk.sv
module rpt_alarm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       irq,
   input logic       en,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [7:0] sec_q,
   input logic [7:0] hour_q
);
   // R11
   irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick));
   // R12
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(en));
   // R1
   sec_undisturbed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != 3'd0) |=> $stable(sec_q));
   // R3
   sec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q[3:0] <= 4'd9) && (sec_q[6:4] <= 3'd5));
   // R4
   hour_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hour_q[3:0] <= 4'd9) && ((hour_q[5:4] < 2'd2) || (hour_q[3:0] <= 4'd3)));
endmodule

bind rpt_alarm_cmp rpt_alarm_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .irq     (irq_pulse),
   .en      (en_q),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .sec_q   (fld_q[0]),
   .hour_q  (fld_q[2])
);

// File: tb/rpt_alarm_cmp_bench.sv
module rpt_alarm_cmp_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       tick = 1'b0;
   logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
   logic       irq_pulse;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rpt_alarm_cmp u_rpt_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .now_sec(now_sec),
      .now_min(now_min), .now_hour(now_hour), .now_date(now_date), .irq_pulse(irq_pulse)
   );

   // {expect, alarm date,hour,min,sec, now date,hour,min,sec}
   localparam int NV = 11;
   localparam logic [64:0] VEC [NV] = '{
      {1'b1, 32'h07121530, 32'h07121530},  // R6 full match
      {1'b0, 32'h07121530, 32'h08121530},  // R6 date differs
      {1'b1, 32'h87121530, 32'h08121530},  // R7 daily
      {1'b0, 32'h87121530, 32'h08131530},  // R7 hour differs
      {1'b1, 32'h87921530, 32'h08131530},  // R8 hourly
      {1'b0, 32'h87921530, 32'h08131630},  // R8 minute differs
      {1'b1, 32'h87929530, 32'h01010130},  // R9 per minute
      {1'b0, 32'h87929530, 32'h01010131},  // R9 second differs
      {1'b1, 32'h879295B0, 32'h01020304},  // R10 all flags
      {1'b1, 32'h071215B0, 32'h01020304},  // R10 seconds flag only
      {1'b1, 32'h07921530, 32'h01020304}   // R10 hour flag only
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   // one tick cycle; irq is sampled in the following cycle
   task automatic do_tick(output logic seen);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      seen = irq_pulse;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic seen;
      repeat (3) @(negedge clk);
      // R2 reset state
      check("R2 irq in reset", {7'b0, irq_pulse}, 8'h00);
      rst_n = 1'b1;
      for (int a = 0; a < 5; a++) rd_chk("R2 reset readback", 3'(a), 8'h00);

      wr(3'd4, 8'h01);
      rd_chk("R1 control enable", 3'd4, 8'h01);

      for (int i = 0; i < NV; i++) begin
         wr(3'd0, VEC[i][39:32]);
         wr(3'd1, VEC[i][47:40]);
         wr(3'd2, VEC[i][55:48]);
         wr(3'd3, VEC[i][63:56]);
         now_sec = VEC[i][7:0]; now_min = VEC[i][15:8];
         now_hour = VEC[i][23:16]; now_date = VEC[i][31:24];
         do_tick(seen);
         check($sformatf("R6-R10 vector %0d", i), {7'b0, seen}, {7'b0, VEC[i][64]});
         @(negedge clk);
         check("R11 pulse one cycle", {7'b0, irq_pulse}, 8'h00);
      end

      // R11 no tick, no pulse (per-second mode still set)
      repeat (4) begin
         @(negedge clk);
         check("R11 no tick", {7'b0, irq_pulse}, 8'h00);
      end

      // R12 enable cleared
      wr(3'd4, 8'h00);
      do_tick(seen);
      check("R12 disabled", {7'b0, seen}, 8'h00);

      // R3 seconds and minutes legality
      wr(3'd0, 8'h59);  rd_chk("R3 sec 59", 3'd0, 8'h59);
      wr(3'd0, 8'h60);  rd_chk("R3 sec 60 dropped", 3'd0, 8'h59);
      wr(3'd0, 8'h1A);  rd_chk("R3 sec bad digit", 3'd0, 8'h59);
      wr(3'd0, 8'hD9);  rd_chk("R3 sec flag kept", 3'd0, 8'hD9);
      wr(3'd1, 8'h00);  rd_chk("R3 min 00", 3'd1, 8'h00);
      wr(3'd1, 8'h5A);  rd_chk("R3 min bad digit", 3'd1, 8'h00);
      // R4 hours
      wr(3'd2, 8'h23);  rd_chk("R4 hour 23", 3'd2, 8'h23);
      wr(3'd2, 8'h24);  rd_chk("R4 hour 24 dropped", 3'd2, 8'h23);
      wr(3'd2, 8'h63);  rd_chk("R4 hour high bits", 3'd2, 8'h63);
      // R5 date
      wr(3'd3, 8'h19);  rd_chk("R5 date 19", 3'd3, 8'h19);
      wr(3'd3, 8'h00);  rd_chk("R5 date zero", 3'd3, 8'h19);
      wr(3'd3, 8'h80);  rd_chk("R5 date flag only", 3'd3, 8'h19);
      wr(3'd3, 8'h0B);  rd_chk("R5 date bad digit", 3'd3, 8'h19);
      // R1 unmapped addresses
      wr(3'd6, 8'h42);
      rd_chk("R1 unmapped read", 3'd6, 8'h00);
      rd_chk("R1 sec untouched", 3'd0, 8'hD9);
      rd_chk("R1 ctrl untouched", 3'd4, 8'h00);

      // R2 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_chk("R2 sec after reset", 3'd0, 8'h00);
      rd_chk("R2 hour after reset", 3'd2, 8'h00);
      rd_chk("R2 ctrl after reset", 3'd4, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule